// File: doc/BRIEF.md
# Fuse Security and Signature Access Controller

This block stands between a programming port and a device's configuration store. It keeps a small array of logic fuse words, an eight-byte user signature, a register bank that a tester can preset directly, and a single security bit. Each command arrives as a one-cycle pulse carrying an opcode, an address and a write byte. The controller decides whether the command is allowed and answers exactly one cycle later. The answer carries a reply strobe, a denied flag and a read byte.

While the security bit is clear, every command is honoured. Once the lock command sets the bit, several commands are refused from the very next command onward: fuse pattern readback, programming, direct register preset and signature writes. A refused command gets a denied reply with zero data. Signature reads stay open in both states. The only way back to the unsecured state is a full erase. A full erase blanks the fuse array and drops the lock in one cycle. It leaves the signature and the preset register alone.

A three-state reply machine drives the answer. ST_IDLE means no reply is due. ST_GRANT means the previous command was carried out. ST_DENY means the previous command was refused. Each cycle the machine takes one of three transitions, named after the state it enters: to-idle when no command arrives or the opcode is the no-operation code, to-grant when the policy allows the command, and to-deny when the policy refuses it. Every state can reach every state, so back-to-back commands chain replies without gaps.

Top module: `fuse_guard_ctrl`

## Requirements
- R1: After reset, the outputs are zero: reply strobe, denied flag, read data, security bit and preset register. Every fuse word and every signature byte reads back as zero.
- R2: Opcodes are 0 no-op, 1 program, 2 verify, 3 preset, 4 signature write, 5 signature read, 6 lock and 7 erase. A command with the valid strobe high and a non-zero opcode produces a reply strobe for exactly one cycle, in the following cycle. A no-op, or any cycle with the valid strobe low, produces no reply.
- R3: While unsecured, program stores the write byte at the addressed fuse word. A later verify of that word returns the byte, granted, in the reply cycle.
- R4: While secured, a verify returns zero data and raises the denied flag. The flag lasts only for that one reply cycle.
- R5: While unsecured, preset loads the write byte into the preset register. While secured, preset is denied and the preset register keeps its value.
- R6: Signature read returns the addressed byte and is never denied, whatever the security state. The byte index is the low three address bits.
- R7: While unsecured, signature write stores the byte. While secured, it is denied and the stored byte keeps its value.
- R8: Lock sets the security bit at the edge that accepts it. A command accepted in the very next cycle is already judged as secured. Lock is granted in either state.
- R9: While secured, program is denied.
- R10: Erase is always granted. It clears every fuse word and the security bit at its edge, and keeps the signature bytes and the preset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode, encoding as in R2 |
| cmd_addr | input | 4 | Fuse word address; low three bits index the signature |
| cmd_wdata | input | 8 | Write byte for program, preset and signature write |
| rsp_valid | output | 1 | Reply strobe, one cycle after a command |
| rsp_denied | output | 1 | Reply flag: command refused by the security policy |
| rsp_data | output | 8 | Read byte for verify and signature read, zero otherwise |
| secured | output | 1 | Current security bit |
| preload_q | output | 8 | Preset register contents |

## Verification
The lock and its first victim overlap. In the cycle where the lock's granted reply is on the outputs, the next command is already being judged, so a verify is issued back-to-back with the lock. The bench then expects a granted reply followed at once by a denied, zero-data reply. Erase meets the following verify in the same way: a verify issued right after erase must come back granted and zero. Both orderings are checked against values the bench computes arithmetically for every fuse address and signature byte.

// File: rtl/fuse_guard_pkg.sv
package fuse_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PROG    = 3'd1,
        OP_VERIFY  = 3'd2,
        OP_PRELOAD = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_SIG_RD  = 3'd5,
        OP_LOCK    = 3'd6,
        OP_ERASE   = 3'd7
    } fg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } fg_state_e;

    typedef struct packed {
        logic active;
        logic allow;
        logic wr_logic;
        logic erase;
        logic wr_sig;
        logic load_pre;
        logic set_lock;
    } fg_verdict_t;

endpackage

// File: rtl/fuse_policy.sv
module fuse_policy
    import fuse_guard_pkg::*;
(
    input  logic        valid_i,
    input  fg_op_e      op_i,
    input  logic        secured_i,
    output fg_verdict_t verdict_o
);

    logic active;
    logic allow;
    logic ok;

    assign active = valid_i && (op_i != OP_NOP);

    always_comb begin
        allow = 1'b0;
        unique case (op_i)
            OP_NOP:     allow = 1'b0;
            OP_PROG:    allow = !secured_i;
            OP_VERIFY:  allow = !secured_i;
            OP_PRELOAD: allow = !secured_i;
            OP_SIG_WR:  allow = !secured_i;
            OP_SIG_RD:  allow = 1'b1;
            OP_LOCK:    allow = 1'b1;
            OP_ERASE:   allow = 1'b1;
            default:    allow = 1'b0;
        endcase
    end

    assign ok = active && allow;

    always_comb begin
        verdict_o.active   = active;
        verdict_o.allow    = allow;
        verdict_o.wr_logic = ok && (op_i == OP_PROG);
        verdict_o.erase    = ok && (op_i == OP_ERASE);
        verdict_o.wr_sig   = ok && (op_i == OP_SIG_WR);
        verdict_o.load_pre = ok && (op_i == OP_PRELOAD);
        verdict_o.set_lock = ok && (op_i == OP_LOCK);
    end

endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              erase_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (erase_i) begin
                mem_q[gi] <= '0;
            end else if (wr_en_i && (addr_i == AW'(gi))) begin
                mem_q[gi] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[addr_i];

    // R10: erase blanks the first and last words at once
    assert_erase_blanks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (mem_q[0] == '0) && (mem_q[DEPTH-1] == '0));

    // R3: a program write lands in the addressed word
    assert_prog_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !erase_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));

endmodule

// File: rtl/sig_store.sv
module sig_store #(
    parameter int BYTES  = 8,
    parameter int WORD_W = 8,
    localparam int IW    = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] byte_q [BYTES];

    for (genvar gi = 0; gi < BYTES; gi++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[gi] <= '0;
            end else if (wr_en_i && (idx_i == IW'(gi))) begin
                byte_q[gi] <= wdata_i;
            end
        end
    end

    assign rdata_o = byte_q[idx_i];

    // R7: an accepted signature write is stored in the indexed byte
    assert_sig_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (byte_q[$past(idx_i)] == $past(wdata_i)));

endmodule

// File: rtl/fuse_guard_ctrl.sv
module fuse_guard_ctrl
    import fuse_guard_pkg::*;
#(
    parameter int LOGIC_DEPTH = 16,
    parameter int SIG_BYTES   = 8,
    parameter int WORD_W      = 8,
    localparam int AW         = $clog2(LOGIC_DEPTH),
    localparam int SIG_IW     = $clog2(SIG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_denied,
    output logic [WORD_W-1:0] rsp_data,
    output logic              secured,
    output logic [WORD_W-1:0] preload_q
);

    fg_op_e            op;
    fg_verdict_t       vd;
    fg_state_e         st_q;
    fg_state_e         st_d;
    logic              secured_q;
    logic [WORD_W-1:0] pre_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] data_d;
    logic [WORD_W-1:0] arr_rd;
    logic [WORD_W-1:0] sig_rd;

    assign op = fg_op_e'(cmd_op);

    fuse_policy u_policy (
        .valid_i   (cmd_valid),
        .op_i      (op),
        .secured_i (secured_q),
        .verdict_o (vd)
    );

    fuse_array #(
        .DEPTH  (LOGIC_DEPTH),
        .WORD_W (WORD_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (vd.wr_logic),
        .erase_i (vd.erase),
        .addr_i  (cmd_addr),
        .wdata_i (cmd_wdata),
        .rdata_o (arr_rd)
    );

    sig_store #(
        .BYTES  (SIG_BYTES),
        .WORD_W (WORD_W)
    ) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (vd.wr_sig),
        .idx_i   (cmd_addr[SIG_IW-1:0]),
        .wdata_i (cmd_wdata),
        .rdata_o (sig_rd)
    );

    // Reply state: next state from the policy verdict
    always_comb begin
        st_d = ST_IDLE;
        if (vd.active) begin
            st_d = vd.allow ? ST_GRANT : ST_DENY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Read byte chosen at acceptance, registered for the reply cycle
    always_comb begin
        data_d = '0;
        if (vd.active && vd.allow) begin
            unique case (op)
                OP_VERIFY: data_d = arr_rd;
                OP_SIG_RD: data_d = sig_rd;
                default:   data_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            secured_q <= 1'b0;
            pre_q     <= '0;
        end else begin
            data_q <= data_d;
            if (vd.erase) begin
                secured_q <= 1'b0;
            end else if (vd.set_lock) begin
                secured_q <= 1'b1;
            end
            if (vd.load_pre) begin
                pre_q <= cmd_wdata;
            end
        end
    end

    // Outputs decoded from the reply state
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_denied = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                rsp_valid  = 1'b0;
                rsp_denied = 1'b0;
            end
            ST_GRANT: begin
                rsp_valid  = 1'b1;
                rsp_denied = 1'b0;
            end
            ST_DENY: begin
                rsp_valid  = 1'b1;
                rsp_denied = 1'b1;
            end
            default: begin
                rsp_valid  = 1'b0;
                rsp_denied = 1'b0;
            end
        endcase
    end

    assign rsp_data  = data_q;
    assign secured   = secured_q;
    assign preload_q = pre_q;

    // R2: every real command is answered in the next cycle
    assert_reply_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op != 3'd0)) |=> rsp_valid);

    // R2: no command means no reply
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || (cmd_op == 3'd0)) |=> !rsp_valid);

    // R4: a denied reply never leaks data
    assert_deny_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_valid && (rsp_data == '0)));

    // R4: verify while secured is refused
    assert_verify_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && cmd_valid && (cmd_op == 3'd2)) |=> rsp_denied);

    // R5: a refused preset leaves the preset register alone
    assert_preset_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && cmd_valid && (cmd_op == 3'd3)) |=> $stable(preload_q));

    // R6: signature read is never refused
    assert_sig_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd5)) |=> (rsp_valid && !rsp_denied));

    // R8: lock is sticky unless erased
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && !(cmd_valid && (cmd_op == 3'd7))) |=> secured);

    // R10: erase drops the lock
    assert_erase_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd7)) |=> !secured);

endmodule

// File: tb/test_fuse_guard_ctrl.sv
module test_fuse_guard_ctrl;
    import fuse_guard_pkg::*;

    localparam int DEPTH = 16;
    localparam int SIGN  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic       rsp_valid;
    logic       rsp_denied;
    logic [7:0] rsp_data;
    logic       secured;
    logic [7:0] preload_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fuse_guard_ctrl i_fuse_guard_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_denied (rsp_denied),
        .rsp_data   (rsp_data),
        .secured    (secured),
        .preload_q  (preload_q)
    );

    function automatic logic [7:0] fuse_pat(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] sig_pat(int i);
        return 8'hA0 ^ 8'((i * 19) & 255);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, sample the reply at the next falling edge
    task automatic cmd(string req, fg_op_e op, int addr, int wd,
                       int e_valid, int e_deny, int e_data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = 4'(addr);
        cmd_wdata = 8'(wd);
        @(negedge clk);
        chk(req, "rsp_valid",  rsp_valid,  e_valid);
        chk(req, "rsp_denied", rsp_denied, e_deny);
        chk(req, "rsp_data",   rsp_data,   e_data);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic idle(string req);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(req, "idle rsp_valid",  rsp_valid,  0);
        chk(req, "idle rsp_denied", rsp_denied, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "rsp_denied", rsp_denied, 0);
        chk("R1", "rsp_data", rsp_data, 0);
        chk("R1", "secured", secured, 0);
        chk("R1", "preload_q", preload_q, 0);
        for (int a = 0; a < DEPTH; a++) cmd("R1", OP_VERIFY, a, 0, 1, 0, 0);
        for (int i = 0; i < SIGN; i++) cmd("R1", OP_SIG_RD, i, 0, 1, 0, 0);

        // R3 program then verify every word, back-to-back
        for (int a = 0; a < DEPTH; a++) cmd("R3", OP_PROG, a, fuse_pat(a), 1, 0, 0);
        for (int a = 0; a < DEPTH; a++) cmd("R3", OP_VERIFY, a, 0, 1, 0, fuse_pat(a));

        // R2 no-op and idle strobe give no reply
        cmd("R2", OP_NOP, 3, 8'h55, 0, 0, 0);
        cmd_op = OP_VERIFY;
        idle("R2");
        cmd("R2", OP_VERIFY, 5, 0, 1, 0, fuse_pat(5));
        idle("R2");

        // R5 preset while open
        cmd("R5", OP_PRELOAD, 0, 8'h3C, 1, 0, 0);
        chk("R5", "preload_q", preload_q, 8'h3C);

        // R7, R6 signature write/read while open
        for (int i = 0; i < SIGN; i++) cmd("R7", OP_SIG_WR, i, sig_pat(i), 1, 0, 0);
        for (int i = 0; i < SIGN; i++) cmd("R6", OP_SIG_RD, i + 8, 0, 1, 0, sig_pat(i));

        // R8 lock, then verify in the very next cycle
        cmd("R8", OP_LOCK, 0, 0, 1, 0, 0);
        chk("R8", "secured", secured, 1);
        cmd("R8", OP_VERIFY, 2, 0, 1, 1, 0);
        idle("R4");

        // R4 all verifies denied while secured
        for (int a = 0; a < DEPTH; a++) cmd("R4", OP_VERIFY, a, 0, 1, 1, 0);
        idle("R4");

        // R5 preset refused, register kept
        cmd("R5", OP_PRELOAD, 0, 8'hC3, 1, 1, 0);
        chk("R5", "preload_q held", preload_q, 8'h3C);

        // R7 signature write refused, R6 read still open
        for (int i = 0; i < SIGN; i++) cmd("R7", OP_SIG_WR, i, 8'hFF, 1, 1, 0);
        for (int i = 0; i < SIGN; i++) cmd("R6", OP_SIG_RD, i, 0, 1, 0, sig_pat(i));

        // R9 program refused; R8 repeated lock granted
        cmd("R9", OP_PROG, 1, 8'h77, 1, 1, 0);
        cmd("R8", OP_LOCK, 0, 0, 1, 0, 0);
        chk("R8", "secured kept", secured, 1);

        // R10 erase, then verify back-to-back
        cmd("R10", OP_ERASE, 0, 0, 1, 0, 0);
        chk("R10", "secured cleared", secured, 0);
        for (int a = 0; a < DEPTH; a++) cmd("R10", OP_VERIFY, a, 0, 1, 0, 0);
        chk("R10", "preload_q kept", preload_q, 8'h3C);
        for (int i = 0; i < SIGN; i++) cmd("R10", OP_SIG_RD, i, 0, 1, 0, sig_pat(i));

        // R3 programming works again after erase
        cmd("R3", OP_PROG, 9, 8'hA5, 1, 0, 0);
        cmd("R3", OP_VERIFY, 9, 0, 1, 0, 8'hA5);
        idle("R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule